// File: doc/BRIEF.md
# Debug Breakpoint Request Router

This block collects the causes that can halt program execution in a debug session and turns them into breakpoint requests. It drives two targets: the main CPU and a coprocessor. There are four causes. The first is a coprocessor software-breakpoint instruction. The second is the trigger sequencer reaching its final state. The third is a software write to a trigger bit. The fourth is an external tag hit on either byte lane of an instruction word. A small control word sets the behaviour:
- a 2-bit target field;
- an arm bit;
- a background-debug routing bit;
- an enable for coprocessor software breakpoints.

All causes except the coprocessor software breakpoint are honoured only while the block is armed, and they are steered by the target field. The coprocessor software breakpoint skips both of those. When its enable bit is set, it forces a CPU request, returns the sequencer to its first state and ends any active trace. Every issued breakpoint disarms the block. All outputs are registered single-cycle pulses, and causes that coincide in one cycle merge into one request.

Top module: `dbg_brk_router`

## Requirements
- R1: After reset all request outputs are 0 and the control word is cleared (target 00, disarmed, background routing off, software-breakpoint enable off).
- R2: With target bit 1 set and the block armed, an armed cause (sequencer final state, trigger write or any tag hit) raises `cpu_brk_req` for exactly one cycle, in the cycle after the cause.
- R3: With target bit 0 set and the block armed, an armed cause raises `cop_brk_req` for exactly one cycle, in the cycle after the cause.
- R4: With target field 11 an armed cause raises both `cpu_brk_req` and `cop_brk_req` in the same cycle.
- R5: While disarmed, armed causes produce no request of any kind.
- R6: Any issued breakpoint (CPU or coprocessor request) clears the arm bit, so an armed cause in the next cycle is ignored. A control write in the same cycle takes priority over this clearing.
- R7: A coprocessor software breakpoint while its enable bit is 1 raises `cpu_brk_req`, `seq_reset` and `trace_end` in the next cycle, whatever the arm and target bits are. While the enable bit is 0 it is ignored.
- R8: `cpu_brk_bdm` is 1 exactly when `cpu_brk_req` is 1 and the background routing bit was 1 when the request was formed.
- R9: A hit on either tag lane (`tag_hit[0]` low byte, `tag_hit[1]` high byte) acts as an armed cause. Hits on both lanes at once give one request.
- R10: With target field 00, an armed cause issues nothing and leaves the block armed.
- R11: Causes that coincide in one cycle give one single-cycle pulse on each affected output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Load the control word |
| ctl_tgt | input | 2 | Target field: bit 1 selects the CPU, bit 0 selects the coprocessor |
| ctl_arm | input | 1 | Arm value to load |
| ctl_bdm | input | 1 | Background-debug routing value to load |
| ctl_swbp_en | input | 1 | Coprocessor software-breakpoint enable to load |
| cop_swbrk | input | 1 | Coprocessor software-breakpoint instruction pulse |
| seq_final | input | 1 | Sequencer reached its final state |
| trig_wr | input | 1 | Software wrote the trigger bit |
| tag_hit | input | TAG_LANES | Tag hit per byte lane |
| cpu_brk_req | output | 1 | CPU breakpoint request pulse |
| cpu_brk_bdm | output | 1 | CPU request is to background debug mode |
| cop_brk_req | output | 1 | Coprocessor breakpoint request pulse |
| seq_reset | output | 1 | Return the sequencer to its first state |
| trace_end | output | 1 | Terminate active tracing |

## Verification
The router is driven with random mixes of control writes and cause pulses, checked each cycle against a bench model of the arm bit. This separates errors in target steering, in disarm-after-issue and in write priority. Directed cases then try each target value with a single cause. The coprocessor software breakpoint is applied with the block disarmed and with target 00, to show that it bypasses arming and steering. Coincident causes and hits on both tag lanes show that requests merge into one pulse and do not stretch.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int TGT_W = 2;

  typedef struct packed {
    logic [TGT_W-1:0] tgt;
    logic             arm;
    logic             bdm;
    logic             swbp_en;
  } brk_ctl_t;

  typedef struct packed {
    logic cpu;
    logic bdm;
    logic cop;
    logic seq_rst;
    logic trc_end;
  } brk_req_t;
endpackage

// File: rtl/dbg_brk_ctl.sv
module dbg_brk_ctl
  import dbg_brk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  brk_ctl_t wr_val,
  input  logic     issued,
  output brk_ctl_t ctl_q
);
  brk_ctl_t ctl_d;
  logic     ctl_ce;

  always_comb begin
    ctl_d  = ctl_q;
    ctl_ce = 1'b0;
    if (wr_en) begin
      ctl_d  = wr_val;
      ctl_ce = 1'b1;
    end else if (issued && ctl_q.arm) begin
      ctl_d.arm = 1'b0;
      ctl_ce    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ce) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/dbg_brk_merge.sv
module dbg_brk_merge
  import dbg_brk_pkg::*;
#(
  parameter int TAG_LANES = 2
)(
  input  brk_ctl_t             ctl,
  input  logic                 cop_swbrk,
  input  logic                 seq_final,
  input  logic                 trig_wr,
  input  logic [TAG_LANES-1:0] tag_hit,
  output brk_req_t             req_d,
  output logic                 issued
);
  logic [TAG_LANES-1:0] lane_or;
  logic armed_hit, sw_hit;

  genvar g;
  generate
    for (g = 0; g < TAG_LANES; g++) begin : g_lane
      if (g == 0) begin : g_first
        assign lane_or[g] = tag_hit[g];
      end else begin : g_rest
        assign lane_or[g] = lane_or[g-1] | tag_hit[g];
      end
    end
  endgenerate

  always_comb begin
    armed_hit     = ctl.arm & (seq_final | trig_wr | lane_or[TAG_LANES-1]);
    sw_hit        = ctl.swbp_en & cop_swbrk;
    req_d.cpu     = sw_hit | (armed_hit & ctl.tgt[1]);
    req_d.cop     = armed_hit & ctl.tgt[0];
    req_d.bdm     = req_d.cpu & ctl.bdm;
    req_d.seq_rst = sw_hit;
    req_d.trc_end = sw_hit;
    issued        = req_d.cpu | req_d.cop;
  end
endmodule

// File: rtl/dbg_brk_outreg.sv
module dbg_brk_outreg
  import dbg_brk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  brk_req_t req_d,
  output brk_req_t req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/dbg_brk_router.sv
module dbg_brk_router
  import dbg_brk_pkg::*;
#(
  parameter int TAG_LANES = 2
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr,
  input  logic [1:0]           ctl_tgt,
  input  logic                 ctl_arm,
  input  logic                 ctl_bdm,
  input  logic                 ctl_swbp_en,
  input  logic                 cop_swbrk,
  input  logic                 seq_final,
  input  logic                 trig_wr,
  input  logic [TAG_LANES-1:0] tag_hit,
  output logic                 cpu_brk_req,
  output logic                 cpu_brk_bdm,
  output logic                 cop_brk_req,
  output logic                 seq_reset,
  output logic                 trace_end
);
  brk_ctl_t wr_val, ctl_q;
  brk_req_t req_d, req_q;
  logic     issued;

  always_comb begin
    wr_val.tgt     = ctl_tgt;
    wr_val.arm     = ctl_arm;
    wr_val.bdm     = ctl_bdm;
    wr_val.swbp_en = ctl_swbp_en;
  end

  dbg_brk_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_val(wr_val),
    .issued(issued), .ctl_q(ctl_q)
  );

  dbg_brk_merge #(.TAG_LANES(TAG_LANES)) u_merge (
    .ctl(ctl_q), .cop_swbrk(cop_swbrk), .seq_final(seq_final),
    .trig_wr(trig_wr), .tag_hit(tag_hit), .req_d(req_d), .issued(issued)
  );

  dbg_brk_outreg u_out (
    .clk(clk), .rst_n(rst_n), .req_d(req_d), .req_q(req_q)
  );

  assign cpu_brk_req = req_q.cpu;
  assign cpu_brk_bdm = req_q.bdm;
  assign cop_brk_req = req_q.cop;
  assign seq_reset   = req_q.seq_rst;
  assign trace_end   = req_q.trc_end;
endmodule

// File: rtl/dbg_brk_router_chk.sv
module dbg_brk_router_chk
  import dbg_brk_pkg::*;
#(
  parameter int TAG_LANES = 2
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ctl_wr,
  input logic                 cop_swbrk,
  input logic                 seq_final,
  input logic                 trig_wr,
  input logic [TAG_LANES-1:0] tag_hit,
  input brk_ctl_t             ctl_q,
  input logic                 cpu_brk_req,
  input logic                 cpu_brk_bdm,
  input logic                 cop_brk_req,
  input logic                 seq_reset,
  input logic                 trace_end
);
  logic any_src;
  assign any_src = seq_final | trig_wr | (|tag_hit);

  // R7
  sw_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_swbrk && ctl_q.swbp_en) |=> (cpu_brk_req && seq_reset && trace_end));

  // R7
  sw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reset == trace_end);

  // R8
  bdm_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_brk_bdm |-> cpu_brk_req);

  // R5
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.arm && !(cop_swbrk && ctl_q.swbp_en)) |=> (!cpu_brk_req && !cop_brk_req));

  // R6
  disarm_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.arm && any_src && (ctl_q.tgt != 2'b00) && !ctl_wr) |=> !ctl_q.arm);

  // R10
  no_target_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.arm && (ctl_q.tgt == 2'b00) && !(cop_swbrk && ctl_q.swbp_en) && !ctl_wr)
      |=> (ctl_q.arm && !cop_brk_req));
endmodule

bind dbg_brk_router dbg_brk_router_chk #(.TAG_LANES(TAG_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .cop_swbrk(cop_swbrk),
  .seq_final(seq_final), .trig_wr(trig_wr), .tag_hit(tag_hit), .ctl_q(ctl_q),
  .cpu_brk_req(cpu_brk_req), .cpu_brk_bdm(cpu_brk_bdm),
  .cop_brk_req(cop_brk_req), .seq_reset(seq_reset), .trace_end(trace_end)
);

// File: tb/dbg_brk_router_tb.sv
`timescale 1ns/1ps
module dbg_brk_router_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr, ctl_arm, ctl_bdm, ctl_swbp_en;
  logic [1:0] ctl_tgt;
  logic cop_swbrk, seq_final, trig_wr;
  logic [1:0] tag_hit;
  logic cpu_brk_req, cpu_brk_bdm, cop_brk_req, seq_reset, trace_end;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [1:0] m_tgt;
  logic m_arm, m_bdm, m_en;

  always #4 clk = ~clk;

  dbg_brk_router u_dut (.*);

  function automatic logic [4:0] expect_out(input logic sw, input logic src);
    logic ah, sh, c, p;
    ah = m_arm & src;
    sh = m_en & sw;
    c  = sh | (ah & m_tgt[1]);
    p  = ah & m_tgt[0];
    return {c, c & m_bdm, p, sh, sh};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {cpu_brk_req, cpu_brk_bdm, cop_brk_req, seq_reset, trace_end};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {cpu,bdm,cop,seq,trc} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one cycle after a negedge, check at the following negedge
  task automatic step(input string req, input logic wr, input logic [1:0] tgt,
                      input logic arm, input logic bdm, input logic en,
                      input logic sw, input logic sf, input logic tw, input logic [1:0] th);
    logic [4:0] e;
    ctl_wr = wr; ctl_tgt = tgt; ctl_arm = arm; ctl_bdm = bdm; ctl_swbp_en = en;
    cop_swbrk = sw; seq_final = sf; trig_wr = tw; tag_hit = th;
    e = expect_out(sw, sf | tw | (|th));
    if (wr) begin
      m_tgt = tgt; m_arm = arm; m_bdm = bdm; m_en = en;
    end else if (e[4] | e[2]) begin
      m_arm = 1'b0;
    end
    @(negedge clk);
    check(req, e);
  endtask

  task automatic idle(input string req);
    step(req, 0, 2'b00, 0, 0, 0, 0, 0, 0, 2'b00);
  endtask

  task automatic cfg(input logic [1:0] tgt, input logic arm, input logic bdm, input logic en);
    step("cfg", 1, tgt, arm, bdm, en, 0, 0, 0, 2'b00);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    ctl_wr = 0; ctl_tgt = 0; ctl_arm = 0; ctl_bdm = 0; ctl_swbp_en = 0;
    cop_swbrk = 0; seq_final = 0; trig_wr = 0; tag_hit = 0;
    m_tgt = 0; m_arm = 0; m_bdm = 0; m_en = 0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 5'b0);
    rst_n = 1'b1;
    // R1: cleared control -> armed cause does nothing
    step("R1 cleared control", 0, 2'b00, 0, 0, 0, 0, 1, 1, 2'b11);

    // R2 CPU target
    cfg(2'b10, 1, 0, 0);
    step("R2 cpu target", 0, 2'b00, 0, 0, 0, 0, 1, 0, 2'b00);
    idle("R2 single pulse");
    // R3 coprocessor target
    cfg(2'b01, 1, 0, 0);
    step("R3 cop target", 0, 2'b00, 0, 0, 0, 0, 0, 1, 2'b00);
    idle("R3 single pulse");
    // R4 both, R8 bdm
    cfg(2'b11, 1, 1, 0);
    step("R4 R8 both targets bdm", 0, 2'b00, 0, 0, 0, 0, 1, 0, 2'b00);
    // R6 disarmed now
    step("R6 disarm after issue", 0, 2'b00, 0, 0, 0, 0, 1, 0, 2'b00);
    // R5 disarmed
    cfg(2'b11, 0, 0, 0);
    step("R5 disarmed ignore", 0, 2'b00, 0, 0, 0, 0, 1, 1, 2'b11);
    // R9 each lane, both lanes
    cfg(2'b10, 1, 0, 0);
    step("R9 low lane", 0, 2'b00, 0, 0, 0, 0, 0, 0, 2'b01);
    cfg(2'b10, 1, 0, 0);
    step("R9 high lane", 0, 2'b00, 0, 0, 0, 0, 0, 0, 2'b10);
    cfg(2'b01, 1, 0, 0);
    step("R9 R11 both lanes merged", 0, 2'b00, 0, 0, 0, 0, 1, 1, 2'b11);
    idle("R11 no stretch");
    // R10 target 00 keeps arm
    cfg(2'b00, 1, 0, 0);
    step("R10 no target", 0, 2'b00, 0, 0, 0, 0, 1, 0, 2'b00);
    step("R10 still armed", 0, 2'b00, 0, 0, 0, 0, 0, 1, 2'b00);
    // R7 sw bp bypasses arm/target
    cfg(2'b00, 0, 1, 1);
    step("R7 sw bp disarmed", 0, 2'b00, 0, 0, 0, 1, 0, 0, 2'b00);
    cfg(2'b11, 1, 0, 0);
    step("R7 sw bp disabled", 0, 2'b00, 0, 0, 0, 1, 0, 0, 2'b00);
    // R6 write priority over clear
    cfg(2'b01, 1, 0, 0);
    step("R6 write wins", 1, 2'b01, 1, 0, 0, 0, 1, 0, 2'b00);
    step("R6 rearmed fires", 0, 2'b00, 0, 0, 0, 0, 1, 0, 2'b00);

    // random mix (R2..R11)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R2-R11 random", (r[3:0] == 4'd0), r[5:4], r[6], r[7], r[8],
           (r[11:9] == 3'd0), r[12] & r[13], r[14] & r[15], r[17:16] & r[19:18]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule